// File: doc/BRIEF.md
# Sixteen-Times I/Q Interpolation Chain

This block takes a pair of signed baseband streams, in-phase and quadrature, at a low sample rate and produces both streams at sixteen times that rate. Each stream passes through its own copy of the same chain. Two 2x half-band low-pass interpolators come first and together give a 4x rate change while removing the spectral images that zero-stuffing creates. A three-stage cascaded integrator-comb (CIC) interpolator follows and multiplies the rate by four again.

All logic runs on one fast clock. A new input pair is offered with a one-cycle strobe, and consecutive strobes are at least sixteen cycles apart. Each accepted pair produces sixteen output pairs, each marked by the output strobe. When the strobe arrives every sixteen cycles exactly, the output strobe stays high on every cycle. The CIC gain of sixteen is removed by a rounded right shift of four, so the output word has the input width.

Top module: `iq16_interp`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is low and `out_i`/`out_q` read zero after that edge. Reset clears every delay line, comb and integrator, so the response after reset equals the response of a chain that has only ever seen zeros.
- R2: `in_valid` is high at most once in any 16 consecutive cycles. Each accepted sample yields exactly 16 output strobes. If inputs arrive every 16 cycles, `out_valid` stays high with no gaps from the first output to the last.
- R3: A constant input value c, held long enough to fill the history, gives a steady output of exactly c on both lanes (unity DC gain).
- R4: The I output sequence, in time order, equals this reference. Each half-band stage zero-stuffs by 2 (sample then zero), convolves with taps (-1, 0, 9, 16, 9, 0, -1), then adds 8, shifts right arithmetically by 4 and saturates. The CIC stage zero-stuffs the second stage's output by 4 (sample then three zeros), convolves with (1, 3, 6, 10, 12, 12, 10, 6, 3, 1), then adds 8, shifts right arithmetically by 4 and saturates.
- R5: The Q lane obeys the same reference as R4 on its own input and is not affected by the I data. Both lanes share one output strobe.
- R6: After each rounding step the value is clamped to the signed 12-bit range [-2048, 2047] rather than wrapping.
- R7: The first output of a sample appears after the fifth rising edge that follows the edge which captured `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at the output sample rate |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe marking a new input pair |
| in_i | input | 12 | Signed in-phase input sample |
| in_q | input | 12 | Signed quadrature input sample |
| out_valid | output | 1 | High when an output pair is presented |
| out_i | output | 12 | Signed in-phase output sample |
| out_q | output | 12 | Signed quadrature output sample |

## Verification
The assertions assume that the input strobe never returns within sixteen cycles of its previous pulse. Each half-band stage and the CIC stage depend on that spacing to finish emitting before they take the next sample. The pending-output budget and the lane-lockstep checks also hold only under that spacing. The bench respects this by drawing every inter-sample gap from sixteen upward, using sixteen exactly for the back-to-back streaming runs. It never raises the strobe while a reset is in progress, although it does reset the block while samples are still in flight.

// File: rtl/iq16_pkg.sv
package iq16_pkg;

  localparam int ACC_W = 40;
  typedef logic signed [ACC_W-1:0] acc_t;

  // Round half up by adding 2^(sh-1), shift right arithmetically, clamp to w bits.
  function automatic acc_t round_sat(input acc_t v, input int sh, input int w);
    acc_t half;
    acc_t r;
    acc_t hi;
    acc_t lo;
    half = (sh > 0) ? (acc_t'(1) <<< (sh - 1)) : acc_t'(0);
    r    = (v + half) >>> sh;
    hi   = (acc_t'(1) <<< (w - 1)) - acc_t'(1);
    lo   = -(acc_t'(1) <<< (w - 1));
    if (r > hi)      r = hi;
    else if (r < lo) r = lo;
    return r;
  endfunction

  // Interpolated midpoint of a 7-tap half-band with taps (-1,0,9,16,9,0,-1), scaled by 16.
  function automatic acc_t hb_mid_sum(input acc_t newest, input acc_t n1,
                                      input acc_t n2, input acc_t oldest);
    return acc_t'(9) * (n1 + n2) - (newest + oldest);
  endfunction

endpackage

// File: rtl/iq16_halfband.sv
module iq16_halfband
  import iq16_pkg::*;
#(
  parameter int W       = 12,
  parameter int SPACING = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);

  localparam int TAPS = 4;
  localparam int SH   = 4;
  localparam int TW   = $clog2(SPACING + 1);
  localparam logic [TW-1:0] LAST = TW'(SPACING);

  logic signed [W-1:0] dl [TAPS];
  logic                busy;
  logic [TW-1:0]       tick;
  logic                fire_mid;
  logic                fire_ctr;
  logic signed [W-1:0] mid_val;

  assign fire_mid = busy && (tick == '0);
  assign fire_ctr = busy && (tick == LAST);
  assign mid_val  = W'(round_sat(hb_mid_sum(acc_t'(dl[0]), acc_t'(dl[1]),
                                            acc_t'(dl[2]), acc_t'(dl[3])), SH, W));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) dl[k] <= '0;
      busy      <= 1'b0;
      tick      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire_mid | fire_ctr;
      if (fire_mid)      out_data <= mid_val;
      else if (fire_ctr) out_data <= dl[1];
      if (in_valid) begin
        dl[0] <= in_data;
        for (int k = 1; k < TAPS; k++) dl[k] <= dl[k-1];
        busy <= 1'b1;
        tick <= '0;
      end else if (busy) begin
        tick <= tick + TW'(1);
        if (fire_ctr) busy <= 1'b0;
      end
    end
  end

  AST_HB_SPACING: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !busy); // R2

  AST_HB_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R2

endmodule

// File: rtl/iq16_cic.sv
module iq16_cic
  import iq16_pkg::*;
#(
  parameter int W = 12,
  parameter int R = 4,
  parameter int N = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);

  localparam int RB = $clog2(R);
  localparam int IW = W + N * RB;
  localparam int SH = (N - 1) * RB;
  localparam int CW = $clog2(R + 1);
  localparam logic [CW-1:0] R_CNT = CW'(R);

  logic signed [IW-1:0] cdly  [N];
  logic signed [IW-1:0] comb  [N+1];
  logic signed [IW-1:0] acc   [N];
  logic signed [IW-1:0] nxt   [N];
  logic signed [IW-1:0] stuffed;
  logic signed [IW-1:0] inj;
  logic [CW-1:0]        run_cnt;
  logic                 first;
  logic                 run_active;

  assign comb[0]    = IW'(in_data);
  assign inj        = first ? stuffed : '0;
  assign run_active = (run_cnt != '0);
  assign nxt[0]     = acc[0] + inj;

  for (genvar k = 0; k < N; k++) begin : g_comb
    assign comb[k+1] = comb[k] - cdly[k];
  end

  for (genvar k = 1; k < N; k++) begin : g_integ
    assign nxt[k] = acc[k] + nxt[k-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) begin
        cdly[k] <= '0;
        acc[k]  <= '0;
      end
      stuffed   <= '0;
      run_cnt   <= '0;
      first     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= run_active;
      if (run_active) begin
        for (int k = 0; k < N; k++) acc[k] <= nxt[k];
        out_data <= W'(round_sat(acc_t'(nxt[N-1]), SH, W));
      end
      if (in_valid) begin
        for (int k = 0; k < N; k++) cdly[k] <= comb[k];
        stuffed <= comb[N];
        run_cnt <= R_CNT;
        first   <= 1'b1;
      end else if (run_active) begin
        run_cnt <= run_cnt - CW'(1);
        first   <= 1'b0;
      end
    end
  end

  AST_CIC_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (run_cnt <= CW'(1))); // R2

endmodule

// File: rtl/iq16_lane.sv
module iq16_lane #(
  parameter int W      = 12,
  parameter int SLOT   = 16,
  parameter int STAGES = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data
);

  localparam int HB1_GAP = SLOT / 2;
  localparam int HB2_GAP = SLOT / 4;
  localparam int CIC_R   = 4;

  logic                hb1_valid;
  logic signed [W-1:0] hb1_data;
  logic                hb2_valid;
  logic signed [W-1:0] hb2_data;

  iq16_halfband #(.W(W), .SPACING(HB1_GAP)) u_hb1 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(hb1_valid), .out_data(hb1_data)
  );

  iq16_halfband #(.W(W), .SPACING(HB2_GAP)) u_hb2 (
    .clk(clk), .rst(rst),
    .in_valid(hb1_valid), .in_data(hb1_data),
    .out_valid(hb2_valid), .out_data(hb2_data)
  );

  iq16_cic #(.W(W), .R(CIC_R), .N(STAGES)) u_cic (
    .clk(clk), .rst(rst),
    .in_valid(hb2_valid), .in_data(hb2_data),
    .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/iq16_interp.sv
module iq16_interp #(
  parameter int W          = 12,
  parameter int SLOT       = 16,
  parameter int CIC_STAGES = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  output logic                out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);

  localparam int LANES = 2;
  localparam int RATE  = 16;
  localparam int GW    = $clog2(SLOT + 1);
  localparam int PW    = $clog2(4 * RATE + 1);
  localparam logic [GW-1:0] SLOT_C = GW'(SLOT);
  localparam logic [PW-1:0] RATE_C = PW'(RATE);

  logic signed [W-1:0] lane_in    [LANES];
  logic signed [W-1:0] lane_out   [LANES];
  logic                lane_valid [LANES];

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iq16_lane #(.W(W), .SLOT(SLOT), .STAGES(CIC_STAGES)) u_lane (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_data(lane_in[g]),
      .out_valid(lane_valid[g]), .out_data(lane_out[g])
    );
  end

  assign out_valid = lane_valid[0];
  assign out_i     = lane_out[0];
  assign out_q     = lane_out[1];

  // Observation counters for the assertions below.
  logic [GW-1:0] since_in;
  logic [PW-1:0] pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_in <= SLOT_C;
      pending  <= '0;
    end else begin
      if (in_valid)              since_in <= GW'(1);
      else if (since_in < SLOT_C) since_in <= since_in + GW'(1);
      pending <= pending + (in_valid ? RATE_C : '0) - (out_valid ? PW'(1) : '0);
    end
  end

  AST_IN_GAP: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (since_in == SLOT_C)); // R2

  AST_OUT_BUDGET: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pending != '0)); // R2

  AST_IQ_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
    lane_valid[0] == lane_valid[1]); // R5

endmodule

// File: tb/iq16_interp_test.sv
module iq16_interp_test;

  typedef int iq_q[$];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [11:0] in_i = '0;
  logic signed [11:0] in_q = '0;
  logic out_valid;
  logic signed [11:0] out_i;
  logic signed [11:0] out_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  longint cyc = 0;

  iq_q oi;
  iq_q oq;
  longint first_cyc;
  longint last_cyc;

  iq16_interp uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (oi.size() == 0) first_cyc = cyc;
      last_cyc = cyc;
      oi.push_back(int'(out_i));
      oq.push_back(int'(out_q));
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rs(int s);
    int r;
    r = (s + 8) >>> 4;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  function automatic iq_q hb_ref(iq_q x);
    int taps[7] = '{-1, 0, 9, 16, 9, 0, -1};
    iq_q u;
    iq_q y;
    foreach (x[j]) begin
      u.push_back(x[j]);
      u.push_back(0);
    end
    for (int m = 0; m < u.size(); m++) begin
      int s = 0;
      for (int k = 0; k < 7; k++)
        if (m - k >= 0) s += taps[k] * u[m-k];
      y.push_back(rs(s));
    end
    return y;
  endfunction

  function automatic iq_q cic_ref(iq_q x);
    int taps[10] = '{1, 3, 6, 10, 12, 12, 10, 6, 3, 1};
    iq_q u;
    iq_q y;
    foreach (x[j]) begin
      u.push_back(x[j]);
      for (int z = 0; z < 3; z++) u.push_back(0);
    end
    for (int m = 0; m < u.size(); m++) begin
      int s = 0;
      for (int k = 0; k < 10; k++)
        if (m - k >= 0) s += taps[k] * u[m-k];
      y.push_back(rs(s));
    end
    return y;
  endfunction

  function automatic iq_q chain_ref(iq_q x);
    return cic_ref(hb_ref(hb_ref(x)));
  endfunction

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    check(out_i == 0 && out_q == 0, "R1", "outputs in reset", longint'(out_i), 0);
    rst = 1'b0;
    oi.delete();
    oq.delete();
  endtask

  task automatic feed(iq_q xi, iq_q xq, int gap_lo, int gap_hi, output longint c0);
    c0 = 0;
    foreach (xi[j]) begin
      int gap = int'($urandom_range(gap_hi, gap_lo));
      @(negedge clk);
      if (j == 0) c0 = cyc;
      in_valid = 1'b1;
      in_i = 12'(xi[j]);
      in_q = 12'(xq[j]);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap - 2) @(negedge clk);
    end
  endtask

  task automatic run_seg(string req, iq_q xi, iq_q xq, int gap_lo, int gap_hi, bit cont);
    longint c0;
    iq_q ei;
    iq_q eq;
    apply_reset();
    feed(xi, xq, gap_lo, gap_hi, c0);
    repeat (40) @(negedge clk);
    ei = chain_ref(xi);
    eq = chain_ref(xq);
    check(oi.size() == ei.size(), "R2", "output count", oi.size(), ei.size());
    check(first_cyc - (c0 + 1) == 5, "R7", "first output latency", first_cyc - (c0 + 1), 5);
    if (cont)
      check(last_cyc - first_cyc + 1 == oi.size(), "R2", "gap-free stream",
            last_cyc - first_cyc + 1, oi.size());
    for (int j = 0; j < ei.size() && j < oi.size(); j++) begin
      check(oi[j] == ei[j], req, "I sample", oi[j], ei[j]);
      check(oq[j] == eq[j], "R5", "Q sample", oq[j], eq[j]);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    iq_q xi;
    iq_q xq;
    int mx;
    int mn;
    void'($urandom(32'd2024));

    // R4 impulse on I, delayed negative impulse on Q
    xi = '{1000, 0, 0, 0, 0, 0};
    xq = '{0, -1000, 0, 0, 0, 0};
    run_seg("R4", xi, xq, 16, 16, 1'b1);

    // R3 constant input
    xi.delete(); xq.delete();
    for (int j = 0; j < 12; j++) begin xi.push_back(500); xq.push_back(-731); end
    run_seg("R4", xi, xq, 16, 16, 1'b1);
    for (int j = oi.size() - 16; j < oi.size(); j++) begin
      check(oi[j] == 500, "R3", "I DC level", oi[j], 500);
      check(oq[j] == -731, "R3", "Q DC level", oq[j], -731);
    end

    // R2/R4 random streaming at the fastest legal rate
    xi.delete(); xq.delete();
    for (int j = 0; j < 30; j++) begin
      xi.push_back(int'($urandom_range(4095, 0)) - 2048);
      xq.push_back(int'($urandom_range(4095, 0)) - 2048);
    end
    run_seg("R4", xi, xq, 16, 16, 1'b1);

    // R4 random samples with irregular gaps
    xi.delete(); xq.delete();
    for (int j = 0; j < 20; j++) begin
      xi.push_back(int'($urandom_range(4095, 0)) - 2048);
      xq.push_back(int'($urandom_range(1000, 0)) - 500);
    end
    run_seg("R4", xi, xq, 16, 37, 1'b0);

    // R6 overshoot patterns drive saturation
    xi.delete(); xq.delete();
    for (int j = 0; j < 16; j++) begin
      xi.push_back((j % 4 == 1 || j % 4 == 2) ? 2047 : -2048);
      xq.push_back((j % 4 == 1 || j % 4 == 2) ? -2048 : 2047);
    end
    run_seg("R6", xi, xq, 16, 16, 1'b1);
    mx = -5000; mn = 5000;
    foreach (oi[j]) if (oi[j] > mx) mx = oi[j];
    foreach (oq[j]) if (oq[j] < mn) mn = oq[j];
    check(mx == 2047, "R6", "I clamps at top", mx, 2047);
    check(mn == -2048, "R6", "Q clamps at bottom", mn, -2048);

    // R1 reset while samples are still in flight, then impulse from clean state
    xi.delete(); xq.delete();
    for (int j = 0; j < 5; j++) begin xi.push_back(1500 - 600 * j); xq.push_back(-900 + 400 * j); end
    begin
      longint c_unused;
      feed(xi, xq, 16, 16, c_unused);
    end
    repeat (3) @(negedge clk);
    xi = '{-1700, 300, 0, 0, 0, 0};
    xq = '{800, 0, 0, 0, 0, 0};
    run_seg("R1", xi, xq, 16, 16, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule